// File: doc/BRIEF.md
# Rippled Bit-Slice Greater-or-Equal Comparator

This block compares two unsigned operands and raises one flag when the first is greater than or equal to the second. There is no subtractor and no behavioural comparison inside it. It is a chain of identical one-bit cells that runs from the most significant bit down to the least significant bit. Each cell receives a two-wire verdict from the cell above it: "equal so far" and "greater so far". It then passes an updated verdict to the cell below.

When both verdict wires are low, the operands are already known to be less. Once any verdict is settled, the lower bits cannot change it. The top cell is seeded with "equal, not greater". The flag is high when the last cell reports either greater or equal. The block is purely combinational, and its width is a parameter that defaults to 4.

Top module: `cascade_ge_cmp`

## Requirements
- R1: For every pair of unsigned operands (256 pairs at width 4), `ge_flag` is 1 exactly when `opa >= opb`.
- R2: A cell drives `gt_out` = `gt_in` OR (`eq_in` AND `a_bit` AND NOT `b_bit`).
- R3: A cell drives `eq_out` = `eq_in` AND (`a_bit` equals `b_bit`).
- R4: A cell whose inputs do not have both `eq_in` and `gt_in` high never drives both `eq_out` and `gt_out` high.
- R5: A cell with `gt_in` = 1 drives `gt_out` = 1 whatever its operand bits are.
- R6: A cell with `eq_in` = 0 and `gt_in` = 0 (the "less" verdict) drives both outputs to 0 whatever its operand bits are.
- R7: Equal operands give `ge_flag` = 1, because the top cell is seeded with `eq_in` = 1 and `gt_in` = 0.
- R8: The most significant differing bit decides the result, whatever the lower bits hold. For example, 4'b1000 against 4'b0111 gives 1, and the reverse gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First unsigned operand |
| opb | input | W | Second unsigned operand |
| ge_flag | output | 1 | High when opa is greater than or equal to opb |

## Verification
The assertions inside each cell check the verdict invariants whenever the inputs change: the two outputs are never both high (R4), a "greater" verdict survives down the chain (R5), and a "less" verdict survives down the chain (R6). The assertions at the top check the final flag against the arithmetic relation and against operand equality. Only the bench scenarios show the exact cell truth table across all sixteen cell input combinations. They also show the full 256-pair sweep and the cases where the most significant bit alone decides the result.

// File: rtl/cascade_ge_cmp.sv
module mag_slice (
  input  logic a_bit,
  input  logic b_bit,
  input  logic eq_in,
  input  logic gt_in,
  output logic eq_out,
  output logic gt_out
);
  assign gt_out = gt_in | (eq_in & a_bit & ~b_bit);
  assign eq_out = eq_in & ~(a_bit ^ b_bit);

  always_comb begin
    if (!(eq_in && gt_in))
      a_r4_no_dual: assert (!(eq_out && gt_out)) else $error("R4 dual verdict");
    if (gt_in)
      a_r5_gt_sticky: assert (gt_out) else $error("R5 greater lost");
    if (!eq_in && !gt_in)
      a_r6_lt_sticky: assert (!eq_out && !gt_out) else $error("R6 less lost");
  end
endmodule

module cascade_ge_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         ge_flag
);
  logic [W:0] eq_c;
  logic [W:0] gt_c;

  assign eq_c[W] = 1'b1;
  assign gt_c[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_cell
    mag_slice u_cell (
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .eq_in (eq_c[i+1]),
      .gt_in (gt_c[i+1]),
      .eq_out(eq_c[i]),
      .gt_out(gt_c[i])
    );
  end

  assign ge_flag = gt_c[0] | eq_c[0];

  always_comb begin
    a_r1_ge_match: assert (ge_flag == (opa >= opb)) else $error("R1 flag mismatch");
    if (opa == opb)
      a_r7_equal_ge: assert (ge_flag) else $error("R7 equal not ge");
  end
endmodule

// File: tb/tb_cascade_ge_cmp.sv
module tb_cascade_ge_cmp;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [W-1:0] opa, opb;
  logic ge_flag;
  logic sa, sb, se, sg, seo, sgo;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  cascade_ge_cmp #(.W(W)) dut (.opa(opa), .opb(opb), .ge_flag(ge_flag));
  mag_slice u_slice (.a_bit(sa), .b_bit(sb), .eq_in(se), .gt_in(sg),
                     .eq_out(seo), .gt_out(sgo));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s opa=%0d opb=%0d cell=%b%b%b%b act=%b exp=%b",
               req, opa, opb, sa, sb, se, sg, act, exp);
    end
  endtask

  task automatic drive_top(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    opa = x; opb = y;
    #1;
  endtask

  task automatic t_cell_table;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      {sa, sb, se, sg} = 4'(k);
      #1;
      chk("R2", sgo, sg | (se & sa & ~sb));
      chk("R3", seo, se & (sa == sb));
      if (!(se && sg)) chk("R4", seo & sgo, 1'b0);
      if (sg) chk("R5", sgo, 1'b1);
      if (!se && !sg) begin
        chk("R6", seo, 1'b0);
        chk("R6", sgo, 1'b0);
      end
    end
  endtask

  task automatic t_equal;
    for (int v = 0; v < 16; v++) begin
      drive_top(4'(v), 4'(v));
      chk("R7", ge_flag, 1'b1);
    end
  endtask

  task automatic t_msb_decides;
    drive_top(4'b1000, 4'b0111); chk("R8", ge_flag, 1'b1);
    drive_top(4'b0111, 4'b1000); chk("R8", ge_flag, 1'b0);
    drive_top(4'b0100, 4'b0011); chk("R8", ge_flag, 1'b1);
    drive_top(4'b1011, 4'b1100); chk("R8", ge_flag, 1'b0);
  endtask

  task automatic t_sweep;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        drive_top(4'(x), 4'(y));
        chk("R1", ge_flag, (x >= y) ? 1'b1 : 1'b0);
      end
  endtask

  initial begin
    opa = '0; opb = '0; sa = 0; sb = 0; se = 0; sg = 0;
    drive_top(4'd0, 4'd0);
    chk("R7", ge_flag, 1'b1);
    t_cell_table();
    t_equal();
    t_msb_decides();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule